// File: doc/BRIEF.md
# Shared-Divider Multi-Phase Clock Generator

This block derives four phase-shifted clocks from one input clock. A single period counter, common to all phases, sets the output frequency to the input clock divided by a programmable period value. Each phase then applies its own offset, counted in input clock cycles, to slide its waveform along that shared period. The result is a set of clocks with the same frequency and chosen phase relations. For example, with a period of 100, offset 0 on phase 0 and offset 25 on phase 1, phase 1 lags phase 0 by a quarter period.

Every phase is produced in two forms. The first is a free-running clock with a duty cycle near one half, intended for export to other logic or pins. The second is a single-cycle tick that steps an attached pattern shifter. The shifter can hold the ticks off through a hold input until it is ready to shift or rotate. The free-running clocks keep running while the ticks are held.

Top module: `mpclk_gen`

## Requirements
- R1: While running (enable high and period P >= 2), the shared counter steps 0,1,...,P-1 and wraps to 0. Each output repeats with a period of exactly P input cycles. Outputs are registered and reflect the counter value of the previous cycle, so the first output cycle after enable rises corresponds to count 0.
- R2: For phase i with reduced offset d, let ph = (count - d) mod P. Free-running clock bit i is 1 when ph < floor(P/2) and 0 otherwise.
- R3: Phase i's waveform is delayed by its offset in input cycles. With P = 100, offset 25 on phase 1 and offset 0 on phase 0, clk bit 1 equals clk bit 0 from 25 cycles earlier.
- R4: An offset value greater than or equal to P behaves exactly like offset mod P.
- R5: Tick bit i is 1 for exactly one cycle per period, in the cycle where ph = 0. That cycle coincides with the rising edge of clock bit i.
- R6: While shift_hold_i is high at a clock edge, no tick is produced from that edge. The free-running clocks are unaffected by shift_hold_i.
- R7: A period value of 0 or 1 holds all eight outputs low and keeps the counter at 0.
- R8: With enable_i low the counter returns to 0 and all outputs are low on the next cycle.
- R9: Offset and period values are per-port fields. Phase i's offset is offset_i[16*i+15:16*i] with the default width. Bit i of clk_o and tick_o belongs to phase i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run enable; low clears the counter and outputs |
| period_i | input | CNT_W (16) | Divide value P shared by all phases |
| offset_i | input | PHASES*CNT_W (64) | Per-phase offsets, phase i in field i |
| shift_hold_i | input | 1 | High suppresses the gated ticks |
| clk_o | output | PHASES (4) | Free-running near-50% duty clocks |
| tick_o | output | PHASES (4) | Gated single-cycle ticks for the pattern shifter |

## Verification
The outputs are compared every cycle against a bench model of the counter and phase equations. The stimulus includes a quarter-period offset case that shows the lag between phases, and odd and even periods that show how the half period rounds. It also uses offsets far above the period to exercise the modulo reduction, and periods of 0, 1 and 2 to separate the hold-low case from the fastest valid case. Random configurations with random hold toggling check that ticks are suppressed while the free-running clocks continue. Enable drops in the middle of a period check that the counter restarts from zero.

// File: rtl/mpclk_pkg.sv
package mpclk_pkg;
  localparam int unsigned MPCLK_PHASES = 4;
  localparam int unsigned MPCLK_CNT_W  = 16;
endpackage

// File: rtl/mpclk_counter.sv
module mpclk_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  assign run_o = enable_i && (period_i > ONE);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!run_o)                 cnt_q <= '0;
    else if (cnt_q >= period_i - ONE) cnt_q <= '0;
    else                             cnt_q <= cnt_q + ONE;
  end

  // R1: counter stays inside the period once the period is settled
  assert_cnt_in_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && $past(run_o) && $stable(period_i)) |-> (cnt_q < period_i));

  // R8: stopped counter is at zero
  assert_cnt_cleared_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!enable_i) |-> (cnt_q == '0));
endmodule

// File: rtl/mpclk_offset_reduce.sv
module mpclk_offset_reduce #(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] offset_i,
  output logic [CNT_W-1:0] offset_o
);
  // restoring remainder: one compare/subtract stage per offset bit
  logic [CNT_W:0][CNT_W-1:0] rem;
  assign rem[0] = '0;

  for (genvar g = 0; g < CNT_W; g++) begin : g_stage
    logic [CNT_W:0] wide;
    assign wide = {rem[g], offset_i[CNT_W-1-g]};
    assign rem[g+1] = (wide >= {1'b0, period_i}) ? CNT_W'(wide - {1'b0, period_i})
                                                 : wide[CNT_W-1:0];
  end

  assign offset_o = rem[CNT_W];
endmodule

// File: rtl/mpclk_phase.sv
module mpclk_phase #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] offset_i,
  output logic             clk_o,
  output logic             tick_o
);
  logic [CNT_W-1:0] off_red;
  logic [CNT_W-1:0] phase;
  logic [CNT_W-1:0] half;
  logic             clk_q, tick_q;

  mpclk_offset_reduce #(.CNT_W(CNT_W)) u_reduce (
    .period_i (period_i),
    .offset_i (offset_i),
    .offset_o (off_red)
  );

  assign half  = period_i >> 1;
  assign phase = (cnt_i >= off_red) ? (cnt_i - off_red)
                                    : (cnt_i + (period_i - off_red));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q  <= 1'b0;
      tick_q <= 1'b0;
    end else if (!run_i) begin
      clk_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      clk_q  <= (phase < half);
      tick_q <= (phase == '0) && !hold_i;
    end
  end

  assign clk_o  = clk_q;
  assign tick_o = tick_q;

  // R5: a tick always lands on a high clock cycle
  assert_tick_on_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |-> clk_q);
endmodule

// File: rtl/mpclk_gen.sv
module mpclk_gen
  import mpclk_pkg::*;
#(
  parameter int unsigned PHASES = MPCLK_PHASES,
  parameter int unsigned CNT_W  = MPCLK_CNT_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    enable_i,
  input  logic [CNT_W-1:0]        period_i,
  input  logic [PHASES*CNT_W-1:0] offset_i,
  input  logic                    shift_hold_i,
  output logic [PHASES-1:0]       clk_o,
  output logic [PHASES-1:0]       tick_o
);
  logic             run;
  logic [CNT_W-1:0] cnt;

  mpclk_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .period_i (period_i),
    .run_o    (run),
    .cnt_o    (cnt)
  );

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    mpclk_phase #(.CNT_W(CNT_W)) u_phase (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run),
      .hold_i   (shift_hold_i),
      .cnt_i    (cnt),
      .period_i (period_i),
      .offset_i (offset_i[p*CNT_W +: CNT_W]),
      .clk_o    (clk_o[p]),
      .tick_o   (tick_o[p])
    );
  end

  // R8: disabled block drives nothing high
  assert_off_when_disabled_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!enable_i) |-> (clk_o == '0 && tick_o == '0));

  // R7: degenerate period holds outputs low
  assert_short_period_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(period_i < CNT_W'(2)) |-> (clk_o == '0 && tick_o == '0));

  // R6: ticks only from edges where the shifter did not hold
  assert_hold_blocks_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(shift_hold_i) |-> (tick_o == '0));

  // R5: at most one tick per phase per cycle pair (tick never two cycles in a row)
  assert_tick_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run) && run && $stable(period_i) && $past(tick_o[0]) |-> !tick_o[0]);
endmodule

// File: tb/mpclk_gen_tb_top.sv
`timescale 1ns/1ps
module mpclk_gen_tb_top;
  localparam int PH = 4;
  localparam int W  = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            en = 1'b0;
  logic [W-1:0]    period = '0;
  logic [PH*W-1:0] offs = '0;
  logic            hold = 1'b0;
  logic [PH-1:0]   clk_o, tick_o;

  int total = 0;
  int bad = 0;
  int cnt_m = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mpclk_gen #(.PHASES(PH), .CNT_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .period_i(period),
    .offset_i(offs), .shift_hold_i(hold), .clk_o(clk_o), .tick_o(tick_o)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int phase_of(int cnt, int p, int off);
    int d = off % p;
    return (cnt >= d) ? cnt - d : cnt + p - d;
  endfunction

  // one cycle: expected from model at the edge, compare after it
  task automatic step(string tag);
    logic [PH-1:0] ec, et;
    bit run;
    @(posedge clk);
    run = en && (int'(period) > 1);
    ec = '0; et = '0;
    if (run) begin
      for (int i = 0; i < PH; i++) begin
        int ph = phase_of(cnt_m, int'(period), int'(offs[i*W +: W]));
        ec[i] = (ph < int'(period) / 2);
        et[i] = (ph == 0) && !hold;
      end
    end
    if (!run) cnt_m = 0;
    else if (cnt_m >= int'(period) - 1) cnt_m = 0;
    else cnt_m++;
    @(negedge clk);
    check(clk_o == ec, {tag, " clk"}, int'(clk_o), int'(ec));
    check(tick_o == et, {tag, " tick"}, int'(tick_o), int'(et));
  endtask

  task automatic config_run(int p, int o0, int o1, int o2, int o3);
    en = 1'b0;
    step("R8 stop");
    period = W'(p);
    offs = {W'(o3), W'(o2), W'(o1), W'(o0)};
    en = 1'b1;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int rises;
    int mism;
    logic prev;
    logic [PH-1:0] h0 [300];
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(clk_o == '0 && tick_o == '0, "R8 reset", int'({clk_o, tick_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1, R3: quarter-period lag at P=100
    config_run(100, 0, 25, 50, 75);
    rises = 0; prev = 1'b0;
    for (int t = 0; t < 400; t++) begin
      step("R1 R3 p100");
      if (t < 300) h0[t] = clk_o;
      if (clk_o[0] && !prev) rises++;
      prev = clk_o[0];
    end
    check(rises == 4, "R1 rise count", rises, 4);
    mism = 0;
    for (int t = 125; t < 300; t++) if (h0[t][1] != h0[t-25][0]) mism++;
    check(mism == 0, "R3 lag 25", mism, 0);

    // R2: odd and minimal periods
    config_run(7, 0, 1, 3, 6);
    repeat (30) step("R2 p7");
    config_run(2, 0, 1, 2, 3);
    repeat (10) step("R2 p2");

    // R4: offsets beyond the period
    config_run(100, 130, 65535, 100, 199);
    repeat (220) step("R4 big offset");

    // R7: degenerate periods
    config_run(0, 0, 1, 2, 3);
    repeat (10) step("R7 p0");
    config_run(1, 0, 0, 0, 0);
    repeat (10) step("R7 p1");

    // R6: hold suppresses ticks, clocks keep running
    config_run(9, 0, 2, 4, 8);
    hold = 1'b1;
    repeat (30) step("R6 hold");
    hold = 1'b0;
    repeat (20) step("R6 release");

    // R8: enable drop mid period, restart from zero
    config_run(10, 3, 0, 7, 5);
    repeat (14) step("R8 run");
    en = 1'b0;
    repeat (3) step("R8 off");
    en = 1'b1;
    repeat (25) step("R8 restart");

    // R9 with random fields, periods and hold
    for (int s = 0; s < 40; s++) begin
      config_run(int'($urandom_range(0, 40)), int'($urandom_range(0, 65535)),
                 int'($urandom_range(0, 60)), int'($urandom_range(0, 65535)),
                 int'($urandom_range(0, 45)));
      for (int t = 0; t < 120; t++) begin
        hold = ($urandom_range(0, 3) == 0);
        step("R9 random");
      end
      hold = 1'b0;
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule